// File: doc/BRIEF.md
# Configurable Wake Signal Output Driver

This block turns an internal wake-event strobe into the waveform on one external wake-up pin. Two configuration bits, which sit in two separate software-visible registers, select the waveform. A polarity bit chooses whether the asserted state is high or low. A shape bit chooses between a held level and a single timed pulse. With both bits at zero the pin gives an active-high level, and that is the state after reset.

In the level shapes the pin stays asserted for as long as a wake-status flag is set. An event sets the flag, and software clears it with a write-one-to-clear strobe. In the pulse shapes each accepted event produces exactly one pulse of fixed length. A down-counter times the pulse. Its length is the clock frequency multiplied by 150 ms, and a small override value can replace it for short simulations. Events that arrive while a pulse is running are dropped. A write that changes either configuration bit aborts whatever the pin is doing. The pin then returns to the idle level of the new setting.

Top module: `wake_pin_driver`

## Requirements
- R1: After a synchronous active-low reset, both configuration bits read 0, the wake-status flag is 0 and the pin is low, which is the idle level of the active-high level shape.
- R2: With shape=0 and polarity=0, a wake event drives the pin to 1 from the clock after the event. The pin stays at 1 until a status-clear strobe, and it is 0 from the clock after that strobe.
- R3: With shape=0 and polarity=1, the pin idles at 1. A wake event drives it to 0, and it returns to 1 after a status-clear strobe.
- R4: With shape=1 and polarity=0, a wake event accepted while no pulse is running drives the pin to 1 for exactly PULSE_LEN consecutive cycles, then back to 0. PULSE_LEN is the override parameter when that is nonzero, and CLK_HZ/1000*PULSE_MS otherwise.
- R5: With shape=1 and polarity=1, the pin idles at 1 and an accepted event gives a single low pulse of exactly PULSE_LEN cycles.
- R6: In the pulse shapes, a wake event that arrives while a pulse is running has no effect: the pulse still ends PULSE_LEN cycles after its start, and no second pulse follows.
- R7: A write that changes the value of either configuration bit clears the wake-status flag and any running pulse. From the next clock the pin sits at the idle level of the new setting, even if a wake event arrives in the same cycle.
- R8: Each configuration bit reads back its last written value on its read port. A write that leaves a bit's value unchanged disturbs neither the status flag nor the pin.
- R9: In the level shapes, a wake event and a status-clear strobe in the same cycle leave the status flag set and the pin asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wake_evt | input | 1 | Single-cycle wake-event strobe |
| status_clr | input | 1 | Write-one-to-clear strobe for the wake-status flag |
| wr_pol_en | input | 1 | Write enable for the polarity register bit |
| wr_pol_val | input | 1 | Polarity value to write (1 = asserted low) |
| wr_pat_en | input | 1 | Write enable for the shape register bit |
| wr_pat_val | input | 1 | Shape value to write (1 = pulse, 0 = level) |
| pol_rd | output | 1 | Current polarity bit |
| pat_rd | output | 1 | Current shape bit |
| wake_status | output | 1 | Wake-status flag |
| wake_pin | output | 1 | Wake-up output pin |

## Verification
The bound checker watches the following on every cycle: a set level-mode flag holds until it is cleared, an event beats a same-cycle clear, a changing configuration write forces the idle level, an idle pulse-mode pin stays idle unless an event arrives, and no pulse ever runs longer than its programmed length. The exact pulse length, the low-polarity waveforms, the dropping of an event mid-pulse, the reset values and the read-back of unchanged writes can only be shown by the bench's directed scenarios. Those scenarios count asserted cycles at the pin and compare them with values worked out from the requirements.

// File: rtl/wake_pin_driver.sv
module wake_pin_driver #(
  parameter int unsigned CLK_HZ       = 100_000_000,
  parameter int unsigned PULSE_MS     = 150,
  parameter int unsigned PULSE_CYC_OV = 0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wake_evt,
  input  logic status_clr,
  input  logic wr_pol_en,
  input  logic wr_pol_val,
  input  logic wr_pat_en,
  input  logic wr_pat_val,
  output logic pol_rd,
  output logic pat_rd,
  output logic wake_status,
  output logic wake_pin
);
  localparam int unsigned PULSE_LEN = (PULSE_CYC_OV != 0) ? PULSE_CYC_OV
                                                          : (CLK_HZ / 1000) * PULSE_MS;
  localparam int unsigned CW = $clog2(PULSE_LEN + 1);

  logic          pol_q, pat_q, status_q;
  logic [CW-1:0] cnt_q;

  logic nxt_pol, nxt_pat, mode_chg, busy, active;

  assign nxt_pol  = wr_pol_en ? wr_pol_val : pol_q;
  assign nxt_pat  = wr_pat_en ? wr_pat_val : pat_q;
  assign mode_chg = (nxt_pol != pol_q) || (nxt_pat != pat_q);
  assign busy     = (cnt_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pol_q    <= 1'b0;
      pat_q    <= 1'b0;
      status_q <= 1'b0;
      cnt_q    <= '0;
    end else begin
      pol_q <= nxt_pol;
      pat_q <= nxt_pat;

      if (mode_chg)        status_q <= 1'b0;
      else if (wake_evt)   status_q <= 1'b1;
      else if (status_clr) status_q <= 1'b0;

      if (mode_chg)                       cnt_q <= '0;
      else if (pat_q && wake_evt && !busy) cnt_q <= CW'(PULSE_LEN);
      else if (busy)                      cnt_q <= cnt_q - CW'(1);
    end
  end

  assign active      = pat_q ? busy : status_q;
  assign wake_pin    = active ^ pol_q;
  assign pol_rd      = pol_q;
  assign pat_rd      = pat_q;
  assign wake_status = status_q;
endmodule

// File: rtl/wake_pin_driver_chk.sv
module wake_pin_driver_chk #(
  parameter int unsigned PULSE_LEN = 8
) (
  input logic clk,
  input logic rst_n,
  input logic wake_evt,
  input logic status_clr,
  input logic wr_pol_en,
  input logic wr_pol_val,
  input logic wr_pat_en,
  input logic wr_pat_val,
  input logic pol_rd,
  input logic pat_rd,
  input logic wake_status,
  input logic wake_pin
);
  logic        chg, quiet, idle;
  logic [31:0] run_q;

  assign chg   = (wr_pol_en && (wr_pol_val != pol_rd)) || (wr_pat_en && (wr_pat_val != pat_rd));
  assign quiet = !wr_pol_en && !wr_pat_en;
  assign idle  = (wake_pin == pol_rd);

  always_ff @(posedge clk) begin
    if (!rst_n)               run_q <= '0;
    else if (pat_rd && !idle) run_q <= run_q + 32'd1;
    else                      run_q <= '0;
  end

  assert_level_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!pat_rd && wake_status && !status_clr && quiet) |=> (wake_status && !idle));

  assert_evt_beats_clr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!pat_rd && wake_evt && status_clr && !chg) |=> wake_status);

  assert_mode_abort_R7: assert property (@(posedge clk) disable iff (!rst_n)
    chg |=> (idle && !wake_status));

  assert_pulse_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pat_rd && idle && wake_evt && !chg) |=> !idle);

  assert_no_spurious_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pat_rd && idle && !wake_evt && !chg) |=> idle);

  assert_pulse_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= PULSE_LEN);
endmodule

bind wake_pin_driver wake_pin_driver_chk #(.PULSE_LEN(PULSE_LEN)) u_chk (.*);

// File: tb/wake_pin_driver_bench.sv
module wake_pin_driver_bench;
  localparam int unsigned PLEN = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wake_evt = 1'b0, status_clr = 1'b0;
  logic wr_pol_en = 1'b0, wr_pol_val = 1'b0, wr_pat_en = 1'b0, wr_pat_val = 1'b0;
  logic pol_rd, pat_rd, wake_status, wake_pin;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  wake_pin_driver #(.PULSE_CYC_OV(PLEN)) u_wake_pin_driver (
    .clk(clk), .rst_n(rst_n), .wake_evt(wake_evt), .status_clr(status_clr),
    .wr_pol_en(wr_pol_en), .wr_pol_val(wr_pol_val), .wr_pat_en(wr_pat_en),
    .wr_pat_val(wr_pat_val), .pol_rd(pol_rd), .pat_rd(pat_rd),
    .wake_status(wake_status), .wake_pin(wake_pin)
  );

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_mode(logic pat, logic pol);
    wr_pat_en = 1'b1; wr_pat_val = pat;
    wr_pol_en = 1'b1; wr_pol_val = pol;
    tick();
    wr_pat_en = 1'b0; wr_pol_en = 1'b0;
  endtask

  task automatic fire();
    wake_evt = 1'b1;
    tick();
    wake_evt = 1'b0;
  endtask

  task automatic clear_status();
    status_clr = 1'b1;
    tick();
    status_clr = 1'b0;
  endtask

  task automatic measure(logic asserted_lvl, output int n);
    n = 0;
    while (wake_pin == asserted_lvl && n < 100) begin
      n++;
      tick();
    end
  endtask

  task automatic t_reset_r1();
    check("R1 pol", pol_rd, 0);
    check("R1 pat", pat_rd, 0);
    check("R1 status", wake_status, 0);
    check("R1 pin", wake_pin, 0);
  endtask

  task automatic t_level_high_r2();
    set_mode(1'b0, 1'b0);
    check("R2 idle", wake_pin, 0);
    fire();
    check("R2 asserted", wake_pin, 1);
    tick(5);
    check("R2 held", wake_pin, 1);
    clear_status();
    check("R2 cleared", wake_pin, 0);
    check("R2 status", wake_status, 0);
  endtask

  task automatic t_level_low_r3();
    set_mode(1'b0, 1'b1);
    check("R3 idle", wake_pin, 1);
    fire();
    check("R3 asserted", wake_pin, 0);
    tick(4);
    check("R3 held", wake_pin, 0);
    clear_status();
    check("R3 cleared", wake_pin, 1);
    set_mode(1'b0, 1'b0);
  endtask

  task automatic t_pulse_high_r4();
    int n;
    set_mode(1'b1, 1'b0);
    check("R4 idle", wake_pin, 0);
    fire();
    measure(1'b1, n);
    check("R4 length", n, PLEN);
    tick(5);
    check("R4 after", wake_pin, 0);
  endtask

  task automatic t_pulse_low_r5();
    int n;
    set_mode(1'b1, 1'b1);
    check("R5 idle", wake_pin, 1);
    fire();
    measure(1'b0, n);
    check("R5 length", n, PLEN);
    tick(3);
    check("R5 after", wake_pin, 1);
  endtask

  task automatic t_retrigger_r6();
    int n;
    set_mode(1'b1, 1'b0);
    fire();
    tick(2);
    fire();
    measure(1'b1, n);
    check("R6 length with ignored event", n, PLEN - 3);
    n = 0;
    for (int i = 0; i < 2 * PLEN; i++) begin
      if (wake_pin) n++;
      tick();
    end
    check("R6 no second pulse", n, 0);
  endtask

  task automatic t_mode_abort_r7();
    int n;
    set_mode(1'b0, 1'b0);
    fire();
    check("R7 level asserted", wake_pin, 1);
    wr_pol_en = 1'b1; wr_pol_val = 1'b1; wake_evt = 1'b1;
    tick();
    wr_pol_en = 1'b0; wake_evt = 1'b0;
    check("R7 level aborted pin", wake_pin, 1);
    check("R7 status cleared", wake_status, 0);
    set_mode(1'b1, 1'b0);
    fire();
    tick(2);
    check("R7 pulse running", wake_pin, 1);
    wr_pol_en = 1'b1; wr_pol_val = 1'b1;
    tick();
    wr_pol_en = 1'b0;
    check("R7 pulse aborted pin", wake_pin, 1);
    n = 0;
    for (int i = 0; i < 2 * PLEN; i++) begin
      if (!wake_pin) n++;
      tick();
    end
    check("R7 stays idle", n, 0);
  endtask

  task automatic t_readback_r8();
    set_mode(1'b1, 1'b1);
    check("R8 pat read", pat_rd, 1);
    check("R8 pol read", pol_rd, 1);
    set_mode(1'b0, 1'b0);
    check("R8 pat read0", pat_rd, 0);
    fire();
    set_mode(1'b0, 1'b0);
    check("R8 same write keeps status", wake_status, 1);
    check("R8 same write keeps pin", wake_pin, 1);
    clear_status();
  endtask

  task automatic t_evt_and_clr_r9();
    set_mode(1'b0, 1'b0);
    wake_evt = 1'b1; status_clr = 1'b1;
    tick();
    wake_evt = 1'b0; status_clr = 1'b0;
    check("R9 status", wake_status, 1);
    check("R9 pin", wake_pin, 1);
    clear_status();
    check("R9 then clear", wake_pin, 0);
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick();
    t_reset_r1();
    t_level_high_r2();
    t_level_low_r3();
    t_pulse_high_r4();
    t_pulse_low_r5();
    t_retrigger_r6();
    t_mode_abort_r7();
    t_readback_r8();
    t_evt_and_clr_r9();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int c = 0; c < 200_000; c++) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule